// File: doc/BRIEF.md
# I2S Transmit Serializer

This block turns a stream of 32-bit sample words from a show-ahead transmit FIFO into a standard I2S stream, and drives the bit clock and word-select itself as the clock master. It runs on the master clock. The bit clock is derived from that clock by an 8-bit ratio setting. A 6-bit resolution setting chooses how many bits each channel slot carries. Each FIFO word holds one channel. Only its low-order bits, as many as the resolution, are sent, MSB first. Words are consumed alternately for the left and the right slot.

Every time transmit is switched on, the block first sends one complete frame of zeros, starting with the left slot, and only then starts consuming the FIFO. If the FIFO is empty when a slot begins, that slot carries zeros and nothing is popped. When transmit is switched off, the frame in progress runs to the end of its right slot, and then all three serial outputs rest low. The ratio and resolution are captured when a session starts, so changing them mid-stream has no effect until the next start.

The controller is a three-state machine:
- IDLE: outputs low, clock divider held.
- ZERO: the leading frame of zeros.
- RUN: FIFO data.

The transitions are:
- START (IDLE to ZERO): enable seen while idle.
- PRIMED (ZERO to RUN): the zero frame ends with enable still high.
- ABORT (ZERO to IDLE): the zero frame ends with enable low.
- STOP (RUN to IDLE): a right slot ends with enable low.
- SLOT (RUN to RUN): a slot ends and streaming continues.

Top module: `i2s_tx_serializer`

## Requirements
- R1: After reset, and whenever the block is idle, sck, ws and sd are low, fifo_pop is low and no bit clock edge occurs.
- R2: While active, sck has a period of 2*(ratio+2) master-clock cycles and is high for exactly ratio+2 of them.
- R3: Each slot carries N bits, where N is the resolution setting if it lies in 2..32; any other value is treated as 32.
- R4: A slot carries bits N-1 down to 0 of its word, MSB first, one bit per sck period; the upper bits of the word are dropped.
- R5: ws is 0 for the left slot and 1 for the right slot. It takes the next slot's value during the last bit of the current slot, so it changes one bit period before that slot's MSB.
- R6: After enable rises from idle, the first two slots (left, then right) carry zeros, and the FIFO is not read during them.
- R7: FIFO words are popped in order, one per slot, alternating left and right, with each pop occurring at the sck falling edge that starts the slot.
- R8: A slot that starts with the FIFO empty carries zeros and no pop is issued.
- R9: When enable drops, the current frame is completed through its right slot and the block then returns to idle.
- R10: Ratio and resolution are captured when enable starts a session; changes to them while active do not affect the stream.
- R11: sd and ws change only on falling sck edges, so both are stable while sck is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| ratio_cfg | input | 8 | Bit clock divider setting |
| res_cfg | input | 6 | Bits per channel slot |
| fifo_data | input | 32 | Head word of the transmit FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | One-cycle strobe that consumes the head word |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select: 0 left, 1 right |
| sd | output | 1 | Serial data |

## Verification
The assertions assume a show-ahead FIFO. fifo_empty must describe the word currently on fifo_data, and a pop must take effect at the clock edge where it is asserted. The bench's FIFO model behaves this way, and it also counts any pop that reaches an empty FIFO. The checks do not assume that the configuration inputs are held steady. To exercise the capture rule, the stimulus scrambles ratio and resolution one cycle after each start. Enable is dropped only inside a right slot, so the expected frame count is exact.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ZERO = 2'd1,
        ST_RUN  = 2'd2
    } tx_state_e;

    // Out-of-range slot lengths fall back to the full word width.
    function automatic int clamp_res(input int res, input int word_w);
        return ((res < 2) || (res > word_w)) ? word_w : res;
    endfunction

endpackage

// File: rtl/i2s_tx_clkdiv.sv
module i2s_tx_clkdiv #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [RATIO_W-1:0] ratio,
    output logic               sck,
    output logic               tick_fall
);
    localparam int CNT_W = RATIO_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             sck_q;
    logic             term;

    assign term      = (cnt_q == ({1'b0, ratio} + CNT_W'(1)));
    assign tick_fall = run && term && sck_q;
    assign sck       = sck_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (term) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
    parameter int WORD_W = 32,
    parameter int RES_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [RES_W-1:0]  res,
    input  logic [WORD_W-1:0] word,
    output logic              sd
);
    localparam int SH_W = RES_W + 1;

    logic [WORD_W-1:0] shreg_q;
    logic [SH_W-1:0]   align;

    // Left-justify the low res bits so the slot MSB sits on top.
    assign align = SH_W'(WORD_W) - {1'b0, res};
    assign sd    = shreg_q[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
        end else if (load) begin
            shreg_q <= word << align;
        end else if (shift) begin
            shreg_q <= shreg_q << 1;
        end
    end
endmodule

// File: rtl/i2s_tx_fsm.sv
module i2s_tx_fsm
    import i2s_tx_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int RATIO_W = 8,
    parameter int RES_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_en,
    input  logic [RATIO_W-1:0] ratio_cfg,
    input  logic [RES_W-1:0]   res_cfg,
    input  logic [WORD_W-1:0]  fifo_data,
    input  logic               fifo_empty,
    input  logic               tick_fall,
    output logic               run,
    output logic [RATIO_W-1:0] ratio_lat,
    output logic [RES_W-1:0]   res_lat,
    output logic               ld,
    output logic               shf,
    output logic [WORD_W-1:0]  ld_word,
    output logic               pop,
    output logic               ws,
    output tx_state_e          state
);
    tx_state_e          state_q, state_d;
    logic               ch_q;
    logic [RES_W-1:0]   bit_q;
    logic               ws_q;
    logic [RATIO_W-1:0] ratio_q;
    logic [RES_W-1:0]   res_q;
    logic               last_bit;

    assign last_bit  = (bit_q == (res_q - 1'b1));
    assign run       = (state_q != ST_IDLE);
    assign ratio_lat = ratio_q;
    assign res_lat   = res_q;
    assign ws        = ws_q;
    assign state     = state_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state and per-slot strobes
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        shf     = 1'b0;
        pop     = 1'b0;
        ld_word = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_en) begin
                    state_d = ST_ZERO;
                    ld      = 1'b1;
                end
            end
            ST_ZERO, ST_RUN: begin
                if (tick_fall) begin
                    if (!last_bit) begin
                        shf = 1'b1;
                    end else begin
                        ld = 1'b1;
                        if (!ch_q) begin
                            if ((state_q == ST_RUN) && !fifo_empty) begin
                                ld_word = fifo_data;
                                pop     = 1'b1;
                            end
                        end else if (tx_en) begin
                            state_d = ST_RUN;
                            if (!fifo_empty) begin
                                ld_word = fifo_data;
                                pop     = 1'b1;
                            end
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Slot position, word select and captured configuration
    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q    <= 1'b0;
            bit_q   <= '0;
            ws_q    <= 1'b0;
            ratio_q <= '0;
            res_q   <= RES_W'(WORD_W);
        end else if (state_q == ST_IDLE) begin
            ch_q  <= 1'b0;
            bit_q <= '0;
            ws_q  <= 1'b0;
            if (tx_en) begin
                ratio_q <= ratio_cfg;
                res_q   <= RES_W'(clamp_res(int'(res_cfg), WORD_W));
            end
        end else if (tick_fall) begin
            if (!last_bit) begin
                bit_q <= bit_q + 1'b1;
                ws_q  <= ((bit_q + 1'b1) == (res_q - 1'b1)) ? ~ch_q : ch_q;
            end else begin
                bit_q <= '0;
                ch_q  <= ~ch_q;
                ws_q  <= ~ch_q;
            end
        end
    end
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2s_tx_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int RATIO_W = 8,
    parameter int RES_W   = 6
) (
    input  logic               mclk,
    input  logic               rst,
    input  logic               tx_en,
    input  logic [RATIO_W-1:0] ratio_cfg,
    input  logic [RES_W-1:0]   res_cfg,
    input  logic [WORD_W-1:0]  fifo_data,
    input  logic               fifo_empty,
    output logic               fifo_pop,
    output logic               sck,
    output logic               ws,
    output logic               sd
);
    logic               run;
    logic               tick_fall;
    logic [RATIO_W-1:0] ratio_lat;
    logic [RES_W-1:0]   res_lat;
    logic               ld;
    logic               shf;
    logic [WORD_W-1:0]  ld_word;
    tx_state_e          fsm_state;

    i2s_tx_fsm #(
        .WORD_W (WORD_W),
        .RATIO_W(RATIO_W),
        .RES_W  (RES_W)
    ) fsm_i (
        .clk       (mclk),
        .rst       (rst),
        .tx_en     (tx_en),
        .ratio_cfg (ratio_cfg),
        .res_cfg   (res_cfg),
        .fifo_data (fifo_data),
        .fifo_empty(fifo_empty),
        .tick_fall (tick_fall),
        .run       (run),
        .ratio_lat (ratio_lat),
        .res_lat   (res_lat),
        .ld        (ld),
        .shf       (shf),
        .ld_word   (ld_word),
        .pop       (fifo_pop),
        .ws        (ws),
        .state     (fsm_state)
    );

    i2s_tx_clkdiv #(
        .RATIO_W(RATIO_W)
    ) div_i (
        .clk      (mclk),
        .rst      (rst),
        .run      (run),
        .ratio    (ratio_lat),
        .sck      (sck),
        .tick_fall(tick_fall)
    );

    i2s_tx_shifter #(
        .WORD_W(WORD_W),
        .RES_W (RES_W)
    ) shf_i (
        .clk  (mclk),
        .rst  (rst),
        .load (ld),
        .shift(shf),
        .res  (res_lat),
        .word (ld_word),
        .sd   (sd)
    );
endmodule

// File: rtl/i2s_tx_serializer_chk.sv
module i2s_tx_serializer_chk
    import i2s_tx_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int RATIO_W = 8,
    parameter int RES_W   = 6
) (
    input logic               mclk,
    input logic               rst,
    input logic               fifo_empty,
    input logic               fifo_pop,
    input logic               sck,
    input logic               ws,
    input logic               sd,
    input tx_state_e          state,
    input logic [RATIO_W-1:0] ratio_lat,
    input logic [RES_W-1:0]   res_lat
);
    // R1: idle means quiet outputs and no FIFO traffic
    p_idle_quiet_r1: assert property (@(posedge mclk) disable iff (rst)
        (state == ST_IDLE) |-> (!sck && !ws && !sd && !fifo_pop));

    // R3: the captured slot length is always a legal one
    p_res_legal_r3: assert property (@(posedge mclk) disable iff (rst)
        (state != ST_IDLE) |-> ((res_lat >= RES_W'(2)) && (res_lat <= RES_W'(WORD_W))));

    // R5: word select moves only at a falling bit clock edge
    p_ws_on_fall_r5: assert property (@(posedge mclk) disable iff (rst)
        !$stable(ws) |-> ($past(sck) && !sck));

    // R6: a pop inside the zero frame only happens when leaving it for streaming
    p_zero_exit_r6: assert property (@(posedge mclk) disable iff (rst)
        ((state == ST_ZERO) && fifo_pop) |=> (state == ST_RUN));

    // R7: pops coincide with the falling edge that opens a slot
    p_pop_high_r7: assert property (@(posedge mclk) disable iff (rst)
        fifo_pop |-> sck);
    p_pop_fall_r7: assert property (@(posedge mclk) disable iff (rst)
        fifo_pop |=> !sck);

    // R8: never consume from an empty FIFO
    p_no_pop_empty_r8: assert property (@(posedge mclk) disable iff (rst)
        fifo_empty |-> !fifo_pop);

    // R10: captured configuration stays fixed for the whole session
    p_cfg_hold_r10: assert property (@(posedge mclk) disable iff (rst)
        ((state != ST_IDLE) && ($past(state) != ST_IDLE)) |->
            ($stable(ratio_lat) && $stable(res_lat)));

    // R11: data is steady across the high phase of the bit clock
    p_sd_hold_r11: assert property (@(posedge mclk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(sd));
endmodule

bind i2s_tx_serializer i2s_tx_serializer_chk #(
    .WORD_W (WORD_W),
    .RATIO_W(RATIO_W),
    .RES_W  (RES_W)
) chk_i (
    .mclk      (mclk),
    .rst       (rst),
    .fifo_empty(fifo_empty),
    .fifo_pop  (fifo_pop),
    .sck       (sck),
    .ws        (ws),
    .sd        (sd),
    .state     (fsm_state),
    .ratio_lat (ratio_lat),
    .res_lat   (res_lat)
);

// File: tb/i2s_tx_serializer_tb_top.sv
module i2s_tx_serializer_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        tx_en;
    logic [7:0]  ratio_cfg;
    logic [5:0]  res_cfg;
    logic [31:0] fifo_data;
    logic        fifo_empty;
    logic        fifo_pop;
    logic        sck, ws, sd;

    always #4 clk = ~clk;

    i2s_tx_serializer dut_i (
        .mclk(clk), .rst(rst), .tx_en(tx_en), .ratio_cfg(ratio_cfg),
        .res_cfg(res_cfg), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop), .sck(sck), .ws(ws), .sd(sd)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Show-ahead FIFO model
    logic [31:0] fmem [0:63];
    int wr_p = 0;
    int rd_p = 0;
    int pops = 0;
    int pop_bad = 0;
    assign fifo_empty = (rd_p == wr_p);
    assign fifo_data  = fmem[rd_p & 63];

    always @(posedge clk) begin
        if (fifo_pop) begin
            if (rd_p == wr_p) pop_bad <= pop_bad + 1;
            else              rd_p <= rd_p + 1;
            pops <= pops + 1;
        end
    end

    // Session context set by the stimulus
    int      sess_id = 0;
    bit      sess_on = 0;
    int      cur_res = 32;
    bit      cur_clamped = 0;
    int      cur_per = 4;
    int      cur_nw = 0;
    longint  expw [0:63];

    // Receiver / monitor
    int      seen_id = 0;
    int      rx_words = 0;
    int      rx_bits = 0;
    longint  rx_val = 0;
    bit      ws_bad = 0;
    bit      first_rise = 1;
    int      rises = 0;
    int      cyc = 0;
    int      hi_cnt = 0;
    logic    sck_prev = 1'b0;
    logic    sd_at_rise = 1'b0;
    bit      sd_moved = 0;

    always @(negedge clk) begin
        if (sess_id != seen_id) begin
            seen_id = sess_id; rx_words = 0; rx_bits = 0; rx_val = 0;
            ws_bad = 0; first_rise = 1; rises = 0;
        end
        cyc++;
        if (sck && !sck_prev) begin
            if (!sess_on) begin
                check(0, "R1", "bit clock edge while idle", 1, 0);
            end else begin
                bit ch;
                bit expws;
                if (!first_rise) check(cyc == cur_per, "R2/R10", "bit clock period", cyc, cur_per);
                first_rise = 0;
                ch    = rx_words[0];
                expws = (rx_bits == cur_res - 1) ? !ch : ch;
                if (ws !== expws) ws_bad = 1;
                rx_val = (rx_val << 1) | longint'(sd);
                rx_bits++;
                rises++;
                if (rx_bits == cur_res) begin
                    string req;
                    if (rx_words < 2)               req = "R6";
                    else if (rx_words >= 2 + cur_nw) req = "R8";
                    else if (cur_clamped)            req = "R3";
                    else                             req = "R4/R7";
                    if (rx_words < 64)
                        check(rx_val == expw[rx_words], req, "received slot word", rx_val, expw[rx_words]);
                    check(!ws_bad, "R5", "word select timing in slot", ws_bad, 0);
                    rx_words++; rx_bits = 0; rx_val = 0; ws_bad = 0;
                end
            end
            cyc = 0; hi_cnt = 1; sd_at_rise = sd; sd_moved = 0;
        end else if (sck && sck_prev) begin
            hi_cnt++;
            if (sd !== sd_at_rise) sd_moved = 1;
        end else if (!sck && sck_prev && sess_on) begin
            check(!sd_moved, "R11", "SD moved while SCK high", sd_moved, 0);
            check(hi_cnt == cur_per / 2, "R2", "bit clock high time", hi_cnt, cur_per / 2);
        end
        sck_prev = sck;
    end

    // One enable session; enable drops once drop_at words are received (odd).
    task automatic run_session(input int r, input int rs, input int nw, input int drop_at);
        int     eff;
        longint mask;
        int     p0;
        int     base;
        eff  = (rs < 2 || rs > 32) ? 32 : rs;
        mask = (longint'(1) << eff) - 1;
        @(negedge clk);
        base = wr_p;
        for (int i = 0; i < 64; i++) expw[i] = 0;
        for (int i = 0; i < nw; i++) begin
            logic [31:0] w;
            w = (32'h9E3779B9 * (i + 1 + r * 7 + rs * 13)) ^ 32'h5A5A0F0F;
            fmem[(base + i) & 63] = w;
            expw[2 + i] = longint'(w) & mask;
        end
        wr_p = base + nw;
        p0 = pops;
        repeat (10) @(negedge clk);
        check(pops == p0, "R1", "no pop while idle with data queued", pops - p0, 0);
        cur_res = eff; cur_clamped = (eff != rs); cur_per = 2 * (r + 2); cur_nw = nw;
        sess_on = 1; sess_id++;
        ratio_cfg = 8'(r); res_cfg = 6'(rs); tx_en = 1'b1;
        @(negedge clk);
        ratio_cfg = ~8'(r); res_cfg = 6'd5;   // scrambled while active (R10)
        while (rx_words < drop_at) @(negedge clk);
        tx_en = 1'b0;
        while (rx_words < drop_at + 1) @(negedge clk);
        repeat (cur_per + 4) @(negedge clk);
        check(rx_words == drop_at + 1, "R9", "frames completed after disable", rx_words, drop_at + 1);
        check(rises == (drop_at + 1) * eff, "R3", "total bits sent", rises, (drop_at + 1) * eff);
        check(sck == 0 && ws == 0 && sd == 0, "R9", "outputs low after stop", {sck, ws, sd}, 0);
        check(pops - p0 == nw, "R7/R8", "pops in session", pops - p0, nw);
        check(pop_bad == 0, "R8", "pop on empty FIFO", pop_bad, 0);
        sess_on = 0;
        repeat (3 * cur_per) @(negedge clk);
    endtask

    initial begin
        int ratios [3] = '{0, 1, 3};
        int reses  [8] = '{2, 3, 8, 16, 24, 32, 0, 45};
        for (int i = 0; i < 64; i++) fmem[i] = '0;
        rst = 1'b1; tx_en = 1'b0; ratio_cfg = '0; res_cfg = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sck == 0 && ws == 0 && sd == 0, "R1", "outputs after reset", {sck, ws, sd}, 0);
        check(fifo_pop == 0, "R1", "pop after reset", fifo_pop, 0);
        foreach (ratios[a]) begin
            foreach (reses[b]) begin
                run_session(ratios[a], reses[b], 4, 9);
            end
        end
        // Disable during the leading zero frame: frame finishes, nothing popped (R6, R9)
        run_session(1, 16, 0, 1);
        run_session(2, 12, 2, 7);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            check(0, "WD", "watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule